// File: doc/BRIEF.md
# External Bus Width Adapter

This block connects a byte-addressed CPU request port to an external static memory bus. The external bus can be 8, 16 or 32 bits wide, and a static strap input selects the width. Each CPU access is a byte, a halfword or a word. The block turns each access into one or more fixed-length external cycles. It drives a word-granular external address made by shifting the CPU byte address right. It places write bytes on the correct data lanes and marks those lanes with active-low byte enables. On reads it picks the right lanes out of the returned data.

When an access is wider than the external port, the block splits it into consecutive external cycles at rising addresses. Each cycle carries the next port-wide slice of the access, lowest bytes first. Read slices are joined little-endian into a single 32-bit result.

The CPU side uses a one-cycle request and a one-cycle ready pulse. Ready comes only after the last external cycle has ended. An access that is not aligned to its own size is refused with an error and never reaches the bus. So is an access with a reserved size or width code.

Top module: `ext_bus_adapter`

## Requirements
- R1: After a synchronous reset the outputs are idle: `ext_cyc`, `cpu_rdy` and `cpu_err` are low, and `ext_ben_n` is 4'b1111.
- R2: The width strap codes are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. The external address of the first cycle is the CPU byte address shifted right by the strap code (0, 1 or 2 bits). The CPU address bits below the shift only select lanes.
- R3: In each external cycle, byte i of that cycle's slice is driven on lane (slice byte address mod port bytes). Lane k is `ext_wdata[8k+7:8k]`. `ext_ben_n[k]` is low exactly on the lanes in use, and there are min(access bytes, port bytes) of them. Unused lanes carry 0, and `ext_wdata` is all zero during read cycles.
- R4: A read narrower than the port takes its bytes from the lanes at (address mod port bytes). It returns them in the low bits of `cpu_rdata`, zero-extended. All other lanes are ignored.
- R5: An access wider than the port becomes (access bytes / port bytes) external cycles, with the external address rising by one per cycle. An access no wider than the port takes exactly one cycle.
- R6: A split read returns the slice of cycle k at `cpu_rdata` bytes k*P to k*P+P-1, where P is the port width in bytes (little-endian assembly).
- R7: Each external cycle keeps `ext_cyc` high, with stable address, enables and data, for exactly LAT clocks. Cycles of one access follow each other with no gap. Read data is sampled on the last clock of each cycle.
- R8: `cpu_rdy` is a one-clock pulse in the clock after the final external cycle ends. `cpu_rdata` is valid with it, and is 0 for writes.
- R9: Size code 3, strap code 3, or an address not aligned to the access size gives `cpu_rdy` and `cpu_err` together in the clock after the request, with `cpu_rdata` 0 and no external cycle. The size codes are 0 = byte, 1 = halfword and 2 = word.
- R10: A request raised while external cycles are in progress is ignored. It produces no extra cycle and no extra ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_port_w | input | 2 | External width strap: 0 = 8, 1 = 16, 2 = 32 bits |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_rdy | output | 1 | Access complete pulse |
| cpu_err | output | 1 | Access refused (with `cpu_rdy`) |
| cpu_rdata | output | 32 | Read result, zero-extended |
| ext_cyc | output | 1 | External cycle active |
| ext_we | output | 1 | External write strobe |
| ext_addr | output | ADDR_W | Port-word address |
| ext_ben_n | output | 4 | Active-low lane enables |
| ext_wdata | output | 32 | Lane-steered write data |
| ext_rdata | input | 32 | Read data from the device |

## Verification
The embedded properties check, on every clock:
- lane enables are all off between cycles, and during a cycle the count of active lanes matches the slice size;
- no lane above the strapped width is ever enabled;
- address, enables and data hold for the whole of each cycle, and the address climbs by one between cycles;
- ready is a single pulse that follows bus activity, and errors never coincide with bus activity.

Only the bench's scenarios can show that the actual bytes land on the right lanes and that read slices come back in the right order. The bench sweeps every size, offset, width and direction against a byte-array memory model. It also shows that a request raised while the block is busy is dropped.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int BUS_DW = 32;
  localparam int NLANE  = BUS_DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    PW_X8  = 2'd0,
    PW_X16 = 2'd1,
    PW_X32 = 2'd2,
    PW_BAD = 2'd3
  } port_w_e;

  // per-access split plan
  typedef struct packed {
    logic       err;   // refuse the access
    logic [1:0] clog;  // log2 of bytes carried per external cycle
    logic [1:0] last;  // index of final beat
    logic [1:0] off;   // first lane used inside the port
  } plan_t;
endpackage

// File: rtl/bwa_plan.sv
module bwa_plan
  import bwa_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] pw,
  input  logic [1:0] addr_lo,
  output plan_t      pl
);
  logic [1:0] amask, wmask, dif;

  always_comb begin
    case (size)
      SZ_WORD: amask = 2'b11;
      SZ_HALF: amask = 2'b01;
      default: amask = 2'b00;
    endcase
    case (pw)
      PW_X32:  wmask = 2'b11;
      PW_X16:  wmask = 2'b01;
      default: wmask = 2'b00;
    endcase
    pl.clog = (size < pw) ? size : pw;
    dif     = size - pl.clog;
    case (dif)
      2'd2:    pl.last = 2'd3;
      2'd1:    pl.last = 2'd1;
      default: pl.last = 2'd0;
    endcase
    pl.off = addr_lo & wmask;
    pl.err = (size == SZ_BAD) || (pw == PW_BAD) || ((addr_lo & amask) != 2'b00);
  end
endmodule

// File: rtl/bwa_lane_steer.sv
module bwa_lane_steer
  import bwa_pkg::*;
(
  input  logic [BUS_DW-1:0] wdata,
  input  logic [1:0]        beat,
  input  logic [1:0]        off,
  input  logic [1:0]        clog,
  output logic [BUS_DW-1:0] lane_data,
  output logic [NLANE-1:0]  lane_en
);
  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    logic [3:0] rel, csz, src;
    logic       inl;
    always_comb begin
      rel = 4'(j) - {2'b00, off};
      csz = 4'd1 << clog;
      inl = (4'(j) >= {2'b00, off}) && (rel < csz);
      src = ({2'b00, beat} << clog) + rel;
      lane_en[j] = inl;
      lane_data[j*8 +: 8] = inl ? wdata[{src[1:0], 3'b000} +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/bwa_read_pack.sv
module bwa_read_pack
  import bwa_pkg::*;
(
  input  logic [BUS_DW-1:0] rdata,
  input  logic [1:0]        beat,
  input  logic [1:0]        off,
  input  logic [1:0]        clog,
  input  logic [BUS_DW-1:0] acc_in,
  output logic [BUS_DW-1:0] acc_out
);
  for (genvar r = 0; r < NLANE; r++) begin : g_byte
    logic [3:0] base, csz, rel;
    logic [1:0] lane;
    logic       inb;
    always_comb begin
      base = {2'b00, beat} << clog;
      csz  = 4'd1 << clog;
      rel  = 4'(r) - base;
      inb  = (4'(r) >= base) && (rel < csz);
      lane = off + rel[1:0];
      acc_out[r*8 +: 8] = inb ? rdata[{lane, 3'b000} +: 8] : acc_in[r*8 +: 8];
    end
  end
endmodule

// File: rtl/ext_bus_adapter.sv
module ext_bus_adapter
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LAT    = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_port_w,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_rdy,
  output logic              cpu_err,
  output logic [31:0]       cpu_rdata,
  output logic              ext_cyc,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [3:0]        ext_ben_n,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

  plan_t              pl;
  logic               busy_r, we_r;
  logic [1:0]         beat_r, last_r, clog_r, off_r, wlog_r, nx_beat;
  logic [CW-1:0]      cnt_r;
  logic [ADDR_W-1:0]  base_r, in_base, next_addr;
  logic [31:0]        wdata_r, acc_r, acc_nx;
  logic [31:0]        st_wdata, st_data;
  logic [1:0]         st_beat, st_off, st_clog;
  logic [3:0]         st_en;

  bwa_plan u_plan (
    .size    (cpu_size),
    .pw      (cfg_port_w),
    .addr_lo (cpu_addr[1:0]),
    .pl      (pl)
  );

  // CPU byte address to port-word address
  always_comb begin
    case (cfg_port_w)
      PW_X16:  in_base = {1'b0,  cpu_addr[ADDR_W-1:1]};
      PW_X32:  in_base = {2'b00, cpu_addr[ADDR_W-1:2]};
      default: in_base = cpu_addr;
    endcase
  end

  assign nx_beat   = beat_r + 2'd1;
  assign next_addr = busy_r ? base_r + {{(ADDR_W-2){1'b0}}, nx_beat} : in_base;
  assign st_wdata  = busy_r ? wdata_r : cpu_wdata;
  assign st_beat   = busy_r ? nx_beat : 2'd0;
  assign st_off    = busy_r ? off_r   : pl.off;
  assign st_clog   = busy_r ? clog_r  : pl.clog;

  bwa_lane_steer u_steer (
    .wdata     (st_wdata),
    .beat      (st_beat),
    .off       (st_off),
    .clog      (st_clog),
    .lane_data (st_data),
    .lane_en   (st_en)
  );

  bwa_read_pack u_pack (
    .rdata   (ext_rdata),
    .beat    (beat_r),
    .off     (off_r),
    .clog    (clog_r),
    .acc_in  (acc_r),
    .acc_out (acc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r    <= 1'b0;
      we_r      <= 1'b0;
      beat_r    <= '0;
      last_r    <= '0;
      clog_r    <= '0;
      off_r     <= '0;
      wlog_r    <= '0;
      cnt_r     <= '0;
      base_r    <= '0;
      wdata_r   <= '0;
      acc_r     <= '0;
      cpu_rdy   <= 1'b0;
      cpu_err   <= 1'b0;
      cpu_rdata <= '0;
      ext_cyc   <= 1'b0;
      ext_we    <= 1'b0;
      ext_addr  <= '0;
      ext_ben_n <= 4'hF;
      ext_wdata <= '0;
    end else begin
      cpu_rdy <= 1'b0;
      cpu_err <= 1'b0;
      if (!busy_r) begin
        if (cpu_req) begin
          if (pl.err) begin
            cpu_rdy   <= 1'b1;
            cpu_err   <= 1'b1;
            cpu_rdata <= '0;
          end else begin
            busy_r    <= 1'b1;
            we_r      <= cpu_we;
            beat_r    <= 2'd0;
            last_r    <= pl.last;
            clog_r    <= pl.clog;
            off_r     <= pl.off;
            wlog_r    <= cfg_port_w;
            base_r    <= in_base;
            wdata_r   <= cpu_wdata;
            acc_r     <= '0;
            cnt_r     <= CNT_LOAD;
            ext_cyc   <= 1'b1;
            ext_we    <= cpu_we;
            ext_addr  <= next_addr;
            ext_ben_n <= ~st_en;
            ext_wdata <= cpu_we ? st_data : 32'h0;
          end
        end
      end else if (cnt_r != '0) begin
        cnt_r <= cnt_r - 1'b1;
      end else begin
        acc_r <= acc_nx;
        if (beat_r == last_r) begin
          busy_r    <= 1'b0;
          ext_cyc   <= 1'b0;
          ext_we    <= 1'b0;
          ext_ben_n <= 4'hF;
          ext_wdata <= '0;
          cpu_rdy   <= 1'b1;
          cpu_rdata <= we_r ? 32'h0 : acc_nx;
        end else begin
          beat_r    <= nx_beat;
          cnt_r     <= CNT_LOAD;
          ext_addr  <= next_addr;
          ext_ben_n <= ~st_en;
          ext_wdata <= we_r ? st_data : 32'h0;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  AST_IDLE_LANES_OFF: assert property (@(posedge clk) disable iff (rst)
    !ext_cyc |-> ext_ben_n == 4'hF); // R3
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
    ext_cyc |-> $countones(~ext_ben_n) == (32'd1 << clog_r)); // R3
  AST_X8_LANES: assert property (@(posedge clk) disable iff (rst)
    ext_cyc && wlog_r == PW_X8 |-> ext_ben_n[3:1] == 3'b111); // R3
  AST_X16_LANES: assert property (@(posedge clk) disable iff (rst)
    ext_cyc && wlog_r == PW_X16 |-> ext_ben_n[3:2] == 2'b11); // R3
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ext_cyc && $past(ext_cyc) && $past(cnt_r) != '0 |->
      $stable(ext_addr) && $stable(ext_ben_n) && $stable(ext_wdata)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ext_cyc && $past(ext_cyc) && !$stable(ext_addr) |->
      ext_addr == $past(ext_addr) + 1'b1); // R5
  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |=> !cpu_rdy); // R8
  AST_RDY_AFTER_BUS: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy && !cpu_err |-> $past(ext_cyc) && !ext_cyc); // R8
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    cpu_err |-> cpu_rdy && !ext_cyc && !$past(ext_cyc)); // R9
endmodule

// File: tb/ext_bus_adapter_test.sv
`timescale 1ns/1ps
module ext_bus_adapter_test;
  localparam int AW  = 20;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_w = 2'd0;
  logic          req = 1'b0, we = 1'b0;
  logic [1:0]    size = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          rdy, err, ecyc, ewe;
  logic [31:0]   rdata, ewdata, erdata;
  logic [AW-1:0] eaddr;
  logic [3:0]    eben_n;

  always #2 clk = ~clk;

  ext_bus_adapter #(.ADDR_W(AW), .LAT(LAT)) uut (
    .clk(clk), .rst(rst), .cfg_port_w(cfg_w),
    .cpu_req(req), .cpu_we(we), .cpu_size(size), .cpu_addr(addr), .cpu_wdata(wdata),
    .cpu_rdy(rdy), .cpu_err(err), .cpu_rdata(rdata),
    .ext_cyc(ecyc), .ext_we(ewe), .ext_addr(eaddr), .ext_ben_n(eben_n),
    .ext_wdata(ewdata), .ext_rdata(erdata)
  );

  // behavioural device: byte array, unused lanes carry junk
  logic [7:0] mem [256];
  always_comb begin
    for (int j = 0; j < 4; j++) begin
      int bw;
      int idx;
      bw  = (cfg_w == 2'd3) ? 4 : (1 << cfg_w);
      idx = (int'(eaddr) * bw + j) & 255;
      erdata[j*8 +: 8] = (j < bw) ? mem[idx] : (8'hC3 ^ 8'(j * 17));
    end
  end

  typedef struct packed {
    logic        cyc;
    logic        we;
    logic [31:0] addr;
    logic [3:0]  ben_n;
    logic [31:0] wdata;
    logic        rdy;
    logic        err;
    logic [31:0] rdata;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0, cycles = 0, rdy_seen = 0;
  bit   m_busy = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // compare every clock, away from the active edge
  task automatic tick();
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = '{cyc:0, we:0, addr:0, ben_n:4'hF, wdata:0, rdy:0, err:0, rdata:0};
    m_busy = e.cyc;
    if (rdy) rdy_seen++;
    chk(ecyc == e.cyc, "R7 ext_cyc", 32'(ecyc), 32'(e.cyc));
    chk(eben_n == e.ben_n, "R3 ext_ben_n", 32'(eben_n), 32'(e.ben_n));
    if (e.cyc) begin
      chk(ewe == e.we, "R7 ext_we", 32'(ewe), 32'(e.we));
      chk(eaddr == AW'(e.addr), "R2 R5 ext_addr", 32'(eaddr), e.addr);
      chk(ewdata == e.wdata, "R3 ext_wdata", ewdata, e.wdata);
    end
    chk(rdy == e.rdy, "R8 cpu_rdy", 32'(rdy), 32'(e.rdy));
    chk(err == e.err, "R9 cpu_err", 32'(err), 32'(e.err));
    if (e.rdy) chk(rdata == e.rdata, "R4 R6 cpu_rdata", rdata, e.rdata);
  endtask

  // reference model: builds the expected per-clock trace for one request
  task automatic model(input bit w, input int sz, input int a, input logic [31:0] d);
    exp_t e;
    int A, B, C, n;
    if (m_busy) return; // R10: ignored while busy
    e = '{cyc:0, we:0, addr:0, ben_n:4'hF, wdata:0, rdy:1, err:0, rdata:0};
    A = 1 << sz;
    B = 1 << cfg_w;
    if (sz == 3 || cfg_w == 2'd3 || (a % A) != 0) begin
      e.err = 1;
      q.push_back(e);
      return;
    end
    C = (A < B) ? A : B;
    n = A / C;
    for (int k = 0; k < n; k++) begin
      exp_t b;
      int ba;
      ba = a + k * C;
      b = '{cyc:1, we:w, addr:32'(ba / B), ben_n:4'hF, wdata:0, rdy:0, err:0, rdata:0};
      for (int i = 0; i < C; i++) begin
        int ln;
        ln = (ba + i) % B;
        b.ben_n[ln] = 1'b0;
        if (w) b.wdata[ln*8 +: 8] = d[(k*C + i)*8 +: 8];
      end
      for (int t = 0; t < LAT; t++) q.push_back(b);
    end
    for (int i = 0; i < A; i++) begin
      if (w) mem[(a + i) & 255] = d[i*8 +: 8];
      else   e.rdata[i*8 +: 8] = mem[(a + i) & 255];
    end
    q.push_back(e);
  endtask

  task automatic issue(input bit w, input int sz, input int a, input logic [31:0] d);
    req = 1; we = w; size = 2'(sz); addr = AW'(a); wdata = d;
    model(w, sz, a, d);
    tick();
    req = 0;
    while (q.size() > 0) tick();
    tick();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ecyc == 1'b0, "R1 ext_cyc", 32'(ecyc), 0);
    chk(eben_n == 4'hF, "R1 ext_ben_n", 32'(eben_n), 32'hF);
    chk(rdy == 1'b0, "R1 cpu_rdy", 32'(rdy), 0);
    chk(err == 1'b0, "R1 cpu_err", 32'(err), 0);
    rst = 0;
    tick();

    // sweep widths, directions, sizes, offsets (misaligned ones give R9)
    for (int pw = 0; pw < 3; pw++) begin
      cfg_w = 2'(pw);
      for (int w = 0; w < 2; w++)
        for (int sz = 0; sz < 3; sz++)
          for (int off = 0; off < 4; off++)
            issue(w[0], sz, 64 + 16 * pw + 4 * sz + off, 32'hA1B2C3D4 ^ 32'(pw * 4099 + sz * 257 + off));
      // read back after writes, R4 R6
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off += (1 << sz))
          issue(1'b0, sz, 64 + 16 * pw + 4 * sz + off, 32'h0);
    end

    // R9: reserved size and width codes
    cfg_w = 2'd1;
    issue(1'b0, 3, 8, 32'h0);
    cfg_w = 2'd3;
    issue(1'b1, 0, 8, 32'h55);
    issue(1'b0, 2, 8, 32'h0);

    // R10: second request while a four-cycle split read runs
    cfg_w = 2'd0;
    rdy_seen = 0;
    req = 1; we = 0; size = 2'd2; addr = AW'(200); wdata = 0;
    model(1'b0, 2, 200, 32'h0);
    tick();
    req = 0;
    repeat (2) tick();
    req = 1; we = 1; size = 2'd0; addr = AW'(3); wdata = 32'hEE;
    model(1'b1, 0, 3, 32'hEE);
    tick();
    req = 0;
    while (q.size() > 0) tick();
    repeat (4) tick();
    chk(rdy_seen == 1, "R10 ready pulses", 32'(rdy_seen), 1);

    report();
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<=150000", cycles);
      report();
    end
  end
endmodule